// File: doc/BRIEF.md
# Four-Channel Match Timer

This block holds four independent counters that share one prescaler, with a register file on a simple 32-bit word-addressed write bus and a registered read path. Each channel compares its counter with its own match value. On a match it can raise a latched flag that feeds a single interrupt line, load zero into the counter, or stop the counter. Each channel counts up or down and can be held in synchronous reset through its own control bit.

Every register is reachable through four neighbouring word aliases. These are a plain store, an OR-in, a clear-where-one and an invert-where-one. Software can therefore flip single enable, reset or mode bits without a read-modify-write. The counters and the prescale counter can be read but not written. The interrupt flags are cleared by writing ones to the plain alias.

Top module: `quad_match_timer`

## Requirements
- R1: The word address is split into a register index (bits 9..2) and an alias (bits 1..0). Alias 0 stores the data, alias 1 ORs it in, alias 2 clears the bits written as one, and alias 3 inverts them. This applies to the control, direction, prescaler, match-control, match and counter-mode registers. A read at any alias returns the register. Read data appears on `bus_rdata` one clock after the address is presented.
- R2: Counter n advances by one on each prescale tick while control bit n is set, its reset bit is clear and its mode field is 00. Direction field n (bits 4n+1..4n) equal to 01 counts down, and any other value counts up. The counter wraps in both directions without setting any flag.
- R3: With prescaler value P, the prescale counter runs 0..P and a tick happens once every P+1 clocks while any channel is enabled. P=0 gives a tick on every clock.
- R4: While control bit 4+n is one, counter n and the prescale counter are held at zero. Counting resumes after the bit is cleared.
- R5: A tick that finds counter n equal to match register n sets interrupt flag n (bit n of the flag register).
- R6: With match-control bit 3n+1 set, counter n loads zero on the match tick instead of stepping, so an up count repeats with period M+1 ticks.
- R7: With match-control bit 3n+2 set, a match clears control bit n, and counter n holds the matched value.
- R8: `irq` is one exactly when some flag n is set together with match-control bit 3n. It is registered and changes in the same cycle as the flag.
- R9: In the flag register, alias 0 clears the flags written as one, and aliases 1, 2 and 3 set, clear and invert them. Flag bit 4 is never set by hardware and does not drive `irq`.
- R10: Counter registers (indices 0x03..0x06) and the prescale counter (index 0x08) are read-only. Writes to them leave them unchanged.
- R11: A channel whose counter-mode field (bits 2n+1..2n of index 0x18) is non-zero does not count.
- R12: After reset all registers, `bus_rdata` and `irq` are zero.
- R13: Register indices are: flags 0x00, control 0x01, direction 0x02, counters 0x03..0x06, prescaler 0x07, prescale counter 0x08, match control 0x09, match 0x0A..0x0D and counter mode 0x18. Other indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_waddr | input | 10 | Word address: register index and alias |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt request |

## Verification
The counting function is exercised with several patterns: an up count with a distant match value, a down count from zero that must wrap to all ones without a flag, a prescaled run that separates "tick every clock" from "tick every P+1 clocks", and a frozen channel whose mode field is non-zero. Match handling is tried with reset-on-match, which tells a periodic reload apart from a free run. It is also tried with stop-on-match, which tells a hold at the match value apart from a reload and checks that the enable bit drops. The interrupt gate is toggled while a flag is set, so that flag and enable are shown to be independent. A cycle-level reference model is compared with the read data and the interrupt line on every clock, so a timing slip of one cycle is caught.

// File: rtl/qmt_pkg.sv
package qmt_pkg;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_e;

  localparam logic [7:0] IDX_FLAGS  = 8'h00;
  localparam logic [7:0] IDX_CTRL   = 8'h01;
  localparam logic [7:0] IDX_DIR    = 8'h02;
  localparam logic [7:0] IDX_CNT0   = 8'h03;
  localparam logic [7:0] IDX_PRE    = 8'h07;
  localparam logic [7:0] IDX_PCNT   = 8'h08;
  localparam logic [7:0] IDX_MCTL   = 8'h09;
  localparam logic [7:0] IDX_MATCH0 = 8'h0A;
  localparam logic [7:0] IDX_MODE   = 8'h18;

  // New register value after a write through one of the four aliases
  function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input alias_op_e op);
    case (op)
      OP_STORE: alias_apply = wd;
      OP_SET:   alias_apply = cur | wd;
      OP_CLEAR: alias_apply = cur & ~wd;
      default:  alias_apply = cur ^ wd;
    endcase
  endfunction

endpackage

// File: rtl/qmt_prescale.sv
module qmt_prescale #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] pcount,
  output logic          tick
);

  logic [CW-1:0] pc_q;

  assign tick   = run && !clear && (pc_q == limit);
  assign pcount = pc_q;

  always_ff @(posedge clk) begin
    if (rst || clear)    pc_q <= '0;
    else if (run) begin
      if (pc_q == limit) pc_q <= '0;
      else               pc_q <= pc_q + CW'(1);
    end
  end

  // R3: a tick restarts the prescale count
  p_tick_restart_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pcount == '0));

  // R4: a channel reset bit holds the prescale counter at zero
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pcount == '0));

endmodule

// File: rtl/qmt_channel.sv
module qmt_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          hold,
  input  logic          tick,
  input  logic          down,
  input  logic          timer_mode,
  input  logic          reload_on_hit,
  input  logic          stop_on_hit,
  input  logic [CW-1:0] match_val,
  output logic [CW-1:0] count,
  output logic          hit
);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step  = en && !hold && tick && timer_mode;
  assign hit   = step && (cnt_q == match_val);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold)                  cnt_q <= '0;
    else if (hit && reload_on_hit)    cnt_q <= '0;
    else if (hit && stop_on_hit)      cnt_q <= cnt_q;
    else if (step)                    cnt_q <= down ? cnt_q - CW'(1) : cnt_q + CW'(1);
  end

  // R4: channel held at zero while its reset bit is set
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> (count == '0));

  // R2: single step up
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !hit && !down) |=> (count == $past(count) + CW'(1)));

  // R2: single step down, wrapping below zero
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !hit && down) |=> (count == $past(count) - CW'(1)));

  // R6: reload to zero after a match
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (hit && reload_on_hit) |=> (count == '0));

  // R11: non-timer mode freezes the counter
  p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    (!timer_mode && !hold) |=> $stable(count));

endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-3:0] bus_waddr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  import qmt_pkg::*;

  localparam int RIW  = AW - 4;
  localparam int ENW  = 2 * NCH;
  localparam int MCW  = 3 * NCH;
  localparam int DIRW = 4 * NCH;
  localparam int MODW = 2 * NCH;
  localparam int IRW  = 5;
  localparam int CAPB = 4;

  logic [RIW-1:0] ridx;
  alias_op_e      op;
  assign ridx = bus_waddr[AW-3:2];
  assign op   = alias_op_e'(bus_waddr[1:0]);

  logic sel_flags, sel_ctrl, sel_dir, sel_pre, sel_mctl, sel_mode;
  assign sel_flags = bus_wr && (ridx == RIW'(IDX_FLAGS));
  assign sel_ctrl  = bus_wr && (ridx == RIW'(IDX_CTRL));
  assign sel_dir   = bus_wr && (ridx == RIW'(IDX_DIR));
  assign sel_pre   = bus_wr && (ridx == RIW'(IDX_PRE));
  assign sel_mctl  = bus_wr && (ridx == RIW'(IDX_MCTL));
  assign sel_mode  = bus_wr && (ridx == RIW'(IDX_MODE));

  logic [ENW-1:0]  ctrl_q, ctrl_d;
  logic [DIRW-1:0] dir_q;
  logic [MODW-1:0] mode_q;
  logic [CW-1:0]   pre_q;
  logic [MCW-1:0]  mctl_q, mctl_d;
  logic [CW-1:0]   match_q [NCH];
  logic [IRW-1:0]  ir_q, ir_d;
  logic            irq_q, irq_d;
  logic [31:0]     rdata_q, rd_d;

  logic [CW-1:0]   cnt [NCH];
  logic [NCH-1:0]  hit;
  logic [CW-1:0]   pcnt;
  logic            tick;

  qmt_prescale #(.CW(CW)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (|ctrl_q[NCH-1:0]),
    .clear  (|ctrl_q[ENW-1:NCH]),
    .limit  (pre_q),
    .pcount (pcnt),
    .tick   (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qmt_channel #(.CW(CW)) u_ch (
      .clk           (clk),
      .rst           (rst),
      .en            (ctrl_q[g]),
      .hold          (ctrl_q[NCH+g]),
      .tick          (tick),
      .down          (dir_q[4*g +: 2] == 2'b01),
      .timer_mode    (mode_q[2*g +: 2] == 2'b00),
      .reload_on_hit (mctl_q[3*g+1]),
      .stop_on_hit   (mctl_q[3*g+2]),
      .match_val     (match_q[g]),
      .count         (cnt[g]),
      .hit           (hit[g])
    );

    // R7: stop-on-match drops the enable bit
    p_stop_clears_en_r7: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && mctl_q[3*g+2]) |=> !ctrl_q[g]);

    // R5: a match latches its flag
    p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> ir_q[g]);
  end

  // Next state of registers that hardware also modifies
  always_comb begin
    ctrl_d = ctrl_q;
    if (sel_ctrl) ctrl_d = ENW'(alias_apply(32'(ctrl_q), bus_wdata, op));
    for (int g = 0; g < NCH; g++)
      if (hit[g] && mctl_q[3*g+2]) ctrl_d[g] = 1'b0;

    ir_d = ir_q;
    if (sel_flags) begin
      if (op == OP_STORE) ir_d = ir_q & ~bus_wdata[IRW-1:0];
      else                ir_d = IRW'(alias_apply(32'(ir_q), bus_wdata, op));
    end
    for (int g = 0; g < NCH; g++)
      if (hit[g]) ir_d[g] = 1'b1;

    mctl_d = mctl_q;
    if (sel_mctl) mctl_d = MCW'(alias_apply(32'(mctl_q), bus_wdata, op));

    irq_d = 1'b0;
    for (int g = 0; g < NCH; g++)
      irq_d = irq_d | (ir_d[g] & mctl_d[3*g]);
  end

  // Read mux, registered one cycle
  always_comb begin
    rd_d = '0;
    if (ridx == RIW'(IDX_FLAGS)) rd_d = 32'(ir_q);
    if (ridx == RIW'(IDX_CTRL))  rd_d = 32'(ctrl_q);
    if (ridx == RIW'(IDX_DIR))   rd_d = 32'(dir_q);
    if (ridx == RIW'(IDX_PRE))   rd_d = 32'(pre_q);
    if (ridx == RIW'(IDX_PCNT))  rd_d = 32'(pcnt);
    if (ridx == RIW'(IDX_MCTL))  rd_d = 32'(mctl_q);
    if (ridx == RIW'(IDX_MODE))  rd_d = 32'(mode_q);
    for (int g = 0; g < NCH; g++) begin
      if (ridx == RIW'(IDX_CNT0) + RIW'(g))   rd_d = 32'(cnt[g]);
      if (ridx == RIW'(IDX_MATCH0) + RIW'(g)) rd_d = 32'(match_q[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      dir_q   <= '0;
      mode_q  <= '0;
      pre_q   <= '0;
      mctl_q  <= '0;
      ir_q    <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
      for (int g = 0; g < NCH; g++) match_q[g] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      mctl_q  <= mctl_d;
      ir_q    <= ir_d;
      irq_q   <= irq_d;
      rdata_q <= rd_d;
      if (sel_dir)  dir_q  <= DIRW'(alias_apply(32'(dir_q), bus_wdata, op));
      if (sel_mode) mode_q <= MODW'(alias_apply(32'(mode_q), bus_wdata, op));
      if (sel_pre)  pre_q  <= CW'(alias_apply(32'(pre_q), bus_wdata, op));
      for (int g = 0; g < NCH; g++)
        if (bus_wr && (ridx == RIW'(IDX_MATCH0) + RIW'(g)))
          match_q[g] <= CW'(alias_apply(32'(match_q[g]), bus_wdata, op));
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R9: the capture flag only rises on a software write
  p_capture_sw_only_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_q[CAPB]) |-> $past(bus_wr));

  // R8: interrupt never raised without some flag set
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|ir_q[NCH-1:0]));

endmodule

// File: tb/test_quad_match_timer.sv
module test_quad_match_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  waddr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  quad_match_timer i_quad_match_timer (
    .clk       (clk),
    .rst       (rst),
    .bus_waddr (waddr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  int    nchk = 0;
  int    nfail = 0;
  int    cyc = 0;
  bit    cmp_on = 0;
  string cur_req = "R12";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  m_ctrl;
  logic [15:0] m_dir;
  logic [7:0]  m_mode;
  logic [31:0] m_pre, m_pc;
  logic [11:0] m_mcr;
  logic [31:0] m_mr [4];
  logic [31:0] m_tc [4];
  logic [4:0]  m_ir;
  logic [31:0] m_rd;
  logic        m_irq;

  function automatic logic [31:0] b_alias(input logic [31:0] c, input logic [31:0] w,
                                          input logic [1:0] o);
    if (o == 2'd0)      return w;
    else if (o == 2'd1) return c | w;
    else if (o == 2'd2) return c & ~w;
    else                return c ^ w;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] idx);
    if (idx == 8'h00) return {27'd0, m_ir};
    if (idx == 8'h01) return {24'd0, m_ctrl};
    if (idx == 8'h02) return {16'd0, m_dir};
    if (idx >= 8'h03 && idx <= 8'h06) return m_tc[idx - 8'h03];
    if (idx == 8'h07) return m_pre;
    if (idx == 8'h08) return m_pc;
    if (idx == 8'h09) return {20'd0, m_mcr};
    if (idx >= 8'h0A && idx <= 8'h0D) return m_mr[idx - 8'h0A];
    if (idx == 8'h18) return {24'd0, m_mode};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_dir = 0; m_mode = 0; m_pre = 0; m_pc = 0; m_mcr = 0;
      m_ir = 0; m_rd = 0; m_irq = 0;
      for (int i = 0; i < 4; i++) begin m_mr[i] = 0; m_tc[i] = 0; end
    end else begin
      logic [7:0]  idx;
      logic [1:0]  o;
      logic        run, clr, tk;
      logic [3:0]  hits;
      logic [31:0] ntc [4];
      idx  = waddr[9:2];
      o    = waddr[1:0];
      m_rd = m_read(idx);
      run  = (m_ctrl[3:0] != 0);
      clr  = (m_ctrl[7:4] != 0);
      tk   = run && !clr && (m_pc == m_pre);
      for (int i = 0; i < 4; i++) begin
        logic mv;
        mv = m_ctrl[i] && !m_ctrl[4+i] && tk && (m_mode[2*i +: 2] == 0);
        hits[i] = mv && (m_tc[i] == m_mr[i]);
        ntc[i] = m_tc[i];
        if (m_ctrl[4+i])                     ntc[i] = 0;
        else if (hits[i] && m_mcr[3*i+1])    ntc[i] = 0;
        else if (hits[i] && m_mcr[3*i+2])    ntc[i] = m_tc[i];
        else if (mv) ntc[i] = (m_dir[4*i +: 2] == 2'b01) ? m_tc[i] - 1 : m_tc[i] + 1;
      end
      if (clr) m_pc = 0;
      else if (run) m_pc = (m_pc == m_pre) ? 0 : m_pc + 1;
      for (int i = 0; i < 4; i++) m_tc[i] = ntc[i];
      if (wr) begin
        if (idx == 8'h00) begin
          if (o == 0) m_ir = m_ir & ~wdata[4:0];
          else        m_ir = 5'(b_alias({27'd0, m_ir}, wdata, o));
        end
        if (idx == 8'h01) m_ctrl = 8'(b_alias({24'd0, m_ctrl}, wdata, o));
        if (idx == 8'h02) m_dir  = 16'(b_alias({16'd0, m_dir}, wdata, o));
        if (idx == 8'h07) m_pre  = b_alias(m_pre, wdata, o);
        if (idx == 8'h09) m_mcr  = 12'(b_alias({20'd0, m_mcr}, wdata, o));
        if (idx >= 8'h0A && idx <= 8'h0D)
          m_mr[idx - 8'h0A] = b_alias(m_mr[idx - 8'h0A], wdata, o);
        if (idx == 8'h18) m_mode = 8'(b_alias({24'd0, m_mode}, wdata, o));
      end
      for (int i = 0; i < 4; i++) begin
        if (hits[i] && m_mcr[3*i+2]) m_ctrl[i] = 1'b0;
        if (hits[i]) m_ir[i] = 1'b1;
      end
      m_irq = (m_ir[0] & m_mcr[0]) | (m_ir[1] & m_mcr[3]) |
              (m_ir[2] & m_mcr[6]) | (m_ir[3] & m_mcr[9]);
    end
  end

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check({cur_req, " rdata vs model"}, rdata, m_rd);
      check({cur_req, " irq vs model"}, {31'd0, irq}, {31'd0, m_irq});
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    waddr = a[11:2]; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    waddr = a[11:2];
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;

    // R12: reset state
    cur_req = "R12";
    brd(12'h000, v); check("R12 flags", v, 0);
    brd(12'h010, v); check("R12 ctrl", v, 0);
    brd(12'h0A0, v); check("R12 match0", v, 0);
    brd(12'h180, v); check("R12 mode", v, 0);
    check("R12 irq", {31'd0, irq}, 0);

    // R1: the four write aliases on match register 2
    cur_req = "R1";
    bwr(12'h0C0, 32'hF0); brd(12'h0C0, v); check("R1 store", v, 32'hF0);
    bwr(12'h0C4, 32'h0F); brd(12'h0C0, v); check("R1 set", v, 32'hFF);
    bwr(12'h0C8, 32'h30); brd(12'h0C0, v); check("R1 clear", v, 32'hCF);
    bwr(12'h0CC, 32'hFF); brd(12'h0CC, v); check("R1 toggle via alias read", v, 32'h30);
    bwr(12'h020, 32'hF0F0); brd(12'h028, v); check("R1 dir store", v, 32'hF0F0);
    bwr(12'h02C, 32'hF0F0); brd(12'h020, v); check("R1 dir toggle", v, 0);

    // R13: register map
    cur_req = "R13";
    bwr(12'h0A0, 32'h11); bwr(12'h0B0, 32'h22); bwr(12'h0C0, 32'h33); bwr(12'h0D0, 32'h44);
    brd(12'h0A0, v); check("R13 match0", v, 32'h11);
    brd(12'h0B0, v); check("R13 match1", v, 32'h22);
    brd(12'h0C0, v); check("R13 match2", v, 32'h33);
    brd(12'h0D0, v); check("R13 match3", v, 32'h44);
    bwr(12'h090, 32'h924); brd(12'h090, v); check("R13 match ctrl", v, 32'h924);
    bwr(12'h090, 32'h0);
    bwr(12'h180, 32'hAA); brd(12'h180, v); check("R13 mode", v, 32'hAA);
    bwr(12'h180, 32'h0);
    brd(12'h0E0, v); check("R13 unmapped", v, 0);

    // R2: up count on channel 0
    cur_req = "R2";
    bwr(12'h0A0, 32'h1000);
    bwr(12'h014, 32'h1);
    idle(20);
    bwr(12'h018, 32'h1);
    brd(12'h030, v); check("R2 up count advanced", {31'd0, v > 32'd10}, 1);

    // R10: counters and prescale counter ignore writes
    cur_req = "R10";
    brd(12'h030, v1);
    bwr(12'h030, 32'hDEAD); brd(12'h030, v); check("R10 counter write ignored", v, v1);
    bwr(12'h034, 32'hFFFF); brd(12'h030, v); check("R10 counter set ignored", v, v1);
    brd(12'h080, v1);
    bwr(12'h080, 32'h55); brd(12'h080, v); check("R10 prescale write ignored", v, v1);

    // R3: prescaler 3 on channel 1
    cur_req = "R3";
    bwr(12'h0B0, 32'hFFFF);
    bwr(12'h070, 32'h3);
    bwr(12'h014, 32'h2);
    for (int k = 0; k < 12; k++) begin
      brd(12'h080, v); check("R3 prescale bound", {31'd0, v <= 32'd3}, 1);
    end
    idle(30);

    // R4: channel reset bit holds counter and prescaler at zero
    cur_req = "R4";
    bwr(12'h014, 32'h20);
    idle(3);
    brd(12'h040, v); check("R4 counter held", v, 0);
    brd(12'h080, v); check("R4 prescale held", v, 0);
    bwr(12'h018, 32'h20);
    idle(12);
    brd(12'h040, v); check("R4 counting resumes", {31'd0, v != 0}, 1);
    bwr(12'h018, 32'h2);
    bwr(12'h070, 32'h0);

    // R2: down count wraps below zero without a flag
    cur_req = "R2";
    bwr(12'h020, 32'h100);
    bwr(12'h0C0, 32'h100);
    bwr(12'h014, 32'h4);
    idle(10);
    bwr(12'h018, 32'h4);
    brd(12'h050, v); check("R2 down wrap", {8'd0, v[31:8]}, 32'h00FFFFFF);
    brd(12'h000, v); check("R2 wrap sets no flag", v, 0);

    // R5 R6 R8: periodic reload on channel 0
    cur_req = "R6";
    bwr(12'h014, 32'h10); bwr(12'h018, 32'h10);
    bwr(12'h0A0, 32'h5);
    bwr(12'h090, 32'h3);
    bwr(12'h014, 32'h1);
    for (int k = 0; k < 10; k++) begin
      brd(12'h030, v); check("R6 counter within period", {31'd0, v <= 32'd5}, 1);
    end
    cur_req = "R5";
    brd(12'h000, v); check("R5 flag0 set", v & 32'h1, 1);
    check("R8 irq with flag and enable", {31'd0, irq}, 1);
    bwr(12'h018, 32'h1);
    cur_req = "R8";
    bwr(12'h098, 32'h1);
    idle(1);
    check("R8 irq gated off", {31'd0, irq}, 0);
    bwr(12'h094, 32'h1);
    idle(1);
    check("R8 irq gated on", {31'd0, irq}, 1);
    cur_req = "R9";
    bwr(12'h000, 32'h1);
    brd(12'h000, v); check("R9 write-one clears", v, 0);
    check("R9 irq drops", {31'd0, irq}, 0);

    // R7: stop on match for channel 3
    cur_req = "R7";
    bwr(12'h0D0, 32'h7);
    bwr(12'h094, 32'h800);
    bwr(12'h014, 32'h8);
    idle(20);
    brd(12'h060, v); check("R7 counter holds match", v, 32'h7);
    brd(12'h010, v); check("R7 enable cleared", v & 32'h8, 0);
    brd(12'h000, v); check("R7 flag3 set", v & 32'h8, 32'h8);
    check("R7 irq off without enable", {31'd0, irq}, 0);
    bwr(12'h000, 32'h8);

    // R11: non-zero mode field freezes channel 1
    cur_req = "R11";
    bwr(12'h180, 32'h4);
    brd(12'h040, v1);
    bwr(12'h014, 32'h2);
    idle(10);
    brd(12'h040, v); check("R11 frozen", v, v1);
    bwr(12'h018, 32'h2);
    bwr(12'h180, 32'h0);

    // R9: flag aliases and the capture bit
    cur_req = "R9";
    bwr(12'h094, 32'hFFF);
    bwr(12'h004, 32'h10); brd(12'h000, v); check("R9 set capture", v, 32'h10);
    check("R9 capture no irq", {31'd0, irq}, 0);
    bwr(12'h00C, 32'h10); brd(12'h000, v); check("R9 toggle", v, 0);
    bwr(12'h004, 32'h14); bwr(12'h008, 32'h10);
    brd(12'h000, v); check("R9 clear alias", v, 32'h4);
    check("R9 sw flag with enable drives irq", {31'd0, irq}, 1);
    bwr(12'h000, 32'h1F);
    idle(2);

    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule